// File: doc/BRIEF.md
# Keyed Windowed Watchdog

This block is a windowed watchdog timer. Software reaches it through a plain single-cycle register bus: a write strobe, a read strobe, a byte address and 32-bit write and read data. Nothing happens until software writes a 32-bit unlock word to the control register. That write also loads a down-counter with the programmed period. Once running, the watchdog cannot be stopped by any register write.

To keep the watchdog alive, software writes two key words to the key register in order. The second word counts as a service. A service is accepted only while the counter sits inside the open window, which is a programmable fraction at the tail of the period. A service that lands before the window opens trips the watchdog. So does letting the counter run down to zero.

A trip latches one of two reaction outputs: a non-maskable interrupt request or a reset request. It also sets a sticky status flag that software clears by writing 1. After a trip the counter freezes and further services are ignored. The reaction output stays high until the next system reset.

The bus has no back-pressure. Every strobe is taken in the cycle it is presented, and read data appears one cycle after the read strobe.

Top module: `kww_top`

## Requirements
- R1: After reset both reaction outputs are low, and reads of the enable register (0x00), the status register (0x0C) and the counter register (0x10) return 0.
- R2: Only a write of 0xA98559DA to 0x00 enables the watchdog. Any other value leaves it disabled, with the counter at 0 and no trip. Once it is enabled, no write clears the enable, and writing the unlock word again does not reload the counter. The enable reads back in bit 0 of 0x00.
- R3: The period field at 0x04 holds the low 12 bits of the written word. Enabling loads the counter with the period field shifted left by SHIFT bits. The counter then falls by one per clock, and its value reads back at 0x10.
- R4: A service is a write of 0xE51A to the key register 0x08 followed, as the next key write, by 0xA35C. Both values are compared in the low 16 bits of the data. A key write that breaks this order returns the sequence to its start without reloading the counter.
- R5: The window code at 0x18 selects the open window as a fraction of the reload value L: 0x0005 gives all of L, 0x0050 gives L/2, 0x0500 gives L/4, 0x5000 gives L/8, and any other code gives all of L. The window is open while 1 <= counter <= L >> k.
- R6: A service with the window open reloads the counter to L. A service with the counter above the window trips the watchdog.
- R7: The watchdog trips in the cycle it is enabled and untripped with its counter at 0. A service presented in that same cycle does not rescue it, and the counter remains at 0.
- R8: At the trip, reaction code 0xA in the low 4 bits of 0x14 raises nmi_o. Any other code raises rst_req_o. The choice is fixed at the trip, and the raised output stays high until reset.
- R9: Status bit 1 at 0x0C is set by a trip and cleared by writing 1 to that bit. A trip and a clear in the same cycle leave the bit set, and clearing it does not drop the reaction output.
- R10: After a trip the counter holds its value and further services have no effect on it.
- R11: Read data is registered and appears the cycle after the read strobe. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| bus_wr_i | input | 1 | Write strobe, taken the cycle it is high |
| bus_rd_i | input | 1 | Read strobe, data returned next cycle |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| nmi_o | output | 1 | Latched non-maskable interrupt reaction |
| rst_req_o | output | 1 | Latched reset-request reaction |

## Verification
Two functions can meet in one cycle. A service can arrive in the very cycle the counter has run out, and a status clear can arrive in the cycle a trip sets the flag. The bench counts clocks from the enable write so that the second service key lands once with the counter at 1, where the reload must win. It lands again with the counter at 0, where the trip must win and the counter must read 0. For the second case, it times a write-1 to the status bit onto the expiry edge and then reads the flag back as still set.

// File: rtl/kww_pkg.sv
`timescale 1ns/1ps
package kww_pkg;
  localparam int BUS_W   = 32;
  localparam int KEY_W   = 16;
  localparam int REACT_W = 4;
  localparam int WINC_W  = 16;

  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_LOAD  = 'h04;
  localparam int OFS_KEY   = 'h08;
  localparam int OFS_STAT  = 'h0C;
  localparam int OFS_COUNT = 'h10;
  localparam int OFS_REACT = 'h14;
  localparam int OFS_WIN   = 'h18;

  localparam int STAT_VIOL_BIT = 1;

  localparam logic [BUS_W-1:0]   ENABLE_WORD = 32'hA985_59DA;
  localparam logic [KEY_W-1:0]   KEY_ARM     = 16'hE51A;
  localparam logic [KEY_W-1:0]   KEY_FIRE    = 16'hA35C;
  localparam logic [REACT_W-1:0] REACT_NMI   = 4'hA;

  typedef enum logic {KEY_IDLE = 1'b0, KEY_ARMED = 1'b1} key_st_e;

  // Window code to right-shift of the reload value (0 = whole period).
  function automatic logic [1:0] win_shift(input logic [WINC_W-1:0] code);
    case (code)
      16'h0005: win_shift = 2'd0;
      16'h0050: win_shift = 2'd1;
      16'h0500: win_shift = 2'd2;
      16'h5000: win_shift = 2'd3;
      default:  win_shift = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/kww_regs.sv
`timescale 1ns/1ps
module kww_regs import kww_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int PRE_W  = 12,
  parameter int CNT_W  = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              trip_i,
  output logic              en_o,
  output logic              arm_load_o,
  output logic [PRE_W-1:0]  preload_o,
  output logic              nmi_sel_o,
  output logic [1:0]        win_sh_o,
  output logic              key_wr_o,
  output logic [KEY_W-1:0]  key_o,
  output logic              viol_o,
  output logic [BUS_W-1:0]  rdata_o
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(OFS_LOAD);
  localparam logic [ADDR_W-1:0] A_KEY   = ADDR_W'(OFS_KEY);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_REACT = ADDR_W'(OFS_REACT);
  localparam logic [ADDR_W-1:0] A_WIN   = ADDR_W'(OFS_WIN);

  logic               en_q, viol_q;
  logic [PRE_W-1:0]   pre_q;
  logic [REACT_W-1:0] react_q;
  logic [WINC_W-1:0]  winc_q;
  logic               sel_ctrl, sel_load, sel_stat, sel_react, sel_win;
  logic [BUS_W-1:0]   rd_mux;

  always_comb begin
    sel_ctrl  = wr_i && (addr_i == A_CTRL);
    sel_load  = wr_i && (addr_i == A_LOAD);
    sel_stat  = wr_i && (addr_i == A_STAT);
    sel_react = wr_i && (addr_i == A_REACT);
    sel_win   = wr_i && (addr_i == A_WIN);
  end

  assign arm_load_o = sel_ctrl && (wdata_i == ENABLE_WORD) && !en_q;
  assign key_wr_o   = wr_i && (addr_i == A_KEY);
  assign key_o      = wdata_i[KEY_W-1:0];
  assign en_o       = en_q;
  assign preload_o  = pre_q;
  assign nmi_sel_o  = (react_q == REACT_NMI);
  assign win_sh_o   = win_shift(winc_q);
  assign viol_o     = viol_q;

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      A_CTRL:  rd_mux = BUS_W'(en_q);
      A_LOAD:  rd_mux = BUS_W'(pre_q);
      A_STAT:  rd_mux[STAT_VIOL_BIT] = viol_q;
      A_COUNT: rd_mux = BUS_W'(cnt_i);
      A_REACT: rd_mux = BUS_W'(react_q);
      A_WIN:   rd_mux = BUS_W'(winc_q);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      viol_q  <= 1'b0;
      pre_q   <= '0;
      react_q <= '0;
      winc_q  <= '0;
      rdata_o <= '0;
    end else begin
      if (arm_load_o) en_q <= 1'b1;
      if (sel_load)   pre_q   <= wdata_i[PRE_W-1:0];
      if (sel_react)  react_q <= wdata_i[REACT_W-1:0];
      if (sel_win)    winc_q  <= wdata_i[WINC_W-1:0];
      // a new trip outranks a simultaneous write-1 clear
      if (trip_i)
        viol_q <= 1'b1;
      else if (sel_stat && wdata_i[STAT_VIOL_BIT])
        viol_q <= 1'b0;
      if (rd_i) rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/kww_keyseq.sv
`timescale 1ns/1ps
module kww_keyseq import kww_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_wr_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             fire_o
);
  key_st_e st_q, st_d;

  always_comb begin
    st_d   = st_q;
    fire_o = 1'b0;
    if (key_wr_i) begin
      case (st_q)
        KEY_IDLE:  st_d = (key_i == KEY_ARM) ? KEY_ARMED : KEY_IDLE;
        KEY_ARMED: begin
          // any second key write ends the sequence; only the fire word serves
          fire_o = (key_i == KEY_FIRE);
          st_d   = KEY_IDLE;
        end
        default:   st_d = KEY_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= KEY_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/kww_timer.sv
`timescale 1ns/1ps
module kww_timer #(
  parameter int PRE_W = 12,
  parameter int SHIFT = 13,
  parameter int CNT_W = PRE_W + SHIFT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic             fire_i,
  input  logic [PRE_W-1:0] preload_i,
  input  logic [1:0]       win_sh_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             trip_o,
  output logic             tripped_o
);
  logic [CNT_W-1:0] cnt_q, reload, thresh;
  logic             tripped_q, live, at_zero, in_win, expire, early, serve;

  assign reload  = CNT_W'(preload_i) << SHIFT;
  assign thresh  = reload >> win_sh_i;
  assign live    = en_i && !tripped_q;
  assign at_zero = (cnt_q == '0);
  assign in_win  = !at_zero && (cnt_q <= thresh);
  assign expire  = live && at_zero;
  assign early   = live && fire_i && !at_zero && !in_win;
  assign serve   = live && fire_i && in_win;
  assign trip_o  = expire || early;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      tripped_q <= 1'b0;
    end else begin
      if (trip_o) tripped_q <= 1'b1;
      if (load_i)
        cnt_q <= reload;
      else if (trip_o || tripped_q)
        cnt_q <= cnt_q;
      else if (serve)
        cnt_q <= reload;
      else if (en_i && !at_zero)
        cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt_o     = cnt_q;
  assign tripped_o = tripped_q;
endmodule

// File: rtl/kww_top.sv
`timescale 1ns/1ps
module kww_top import kww_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int PRE_W  = 12,
  parameter int SHIFT  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              nmi_o,
  output logic              rst_req_o
);
  localparam int CNT_W = PRE_W + SHIFT;

  logic             en_w, load_w, nmi_sel_w, key_wr_w, viol_w, fire_w, trip_w, tripped_w;
  logic [PRE_W-1:0] pre_w;
  logic [1:0]       win_sh_w;
  logic [KEY_W-1:0] key_w;
  logic [CNT_W-1:0] cnt_w;
  logic             nmi_q, rreq_q;

  kww_regs #(.ADDR_W(ADDR_W), .PRE_W(PRE_W), .CNT_W(CNT_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(bus_wr_i), .rd_i(bus_rd_i),
    .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .cnt_i(cnt_w), .trip_i(trip_w),
    .en_o(en_w), .arm_load_o(load_w), .preload_o(pre_w), .nmi_sel_o(nmi_sel_w),
    .win_sh_o(win_sh_w), .key_wr_o(key_wr_w), .key_o(key_w), .viol_o(viol_w),
    .rdata_o(bus_rdata_o)
  );

  kww_keyseq u_keys (
    .clk_i(clk_i), .rst_ni(rst_ni), .key_wr_i(key_wr_w), .key_i(key_w), .fire_o(fire_w)
  );

  kww_timer #(.PRE_W(PRE_W), .SHIFT(SHIFT), .CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_w), .load_i(load_w), .fire_i(fire_w),
    .preload_i(pre_w), .win_sh_i(win_sh_w), .cnt_o(cnt_w), .trip_o(trip_w),
    .tripped_o(tripped_w)
  );

  // reaction chosen once, at the trip edge, then held until reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q  <= 1'b0;
      rreq_q <= 1'b0;
    end else if (trip_w && !tripped_w) begin
      nmi_q  <= nmi_sel_w;
      rreq_q <= !nmi_sel_w;
    end
  end

  assign nmi_o     = nmi_q;
  assign rst_req_o = rreq_q;
endmodule

// File: rtl/kww_chk.sv
`timescale 1ns/1ps
module kww_chk #(
  parameter int CNT_W = 25
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             fire,
  input logic [CNT_W-1:0] cnt,
  input logic             nmi,
  input logic             rst_req,
  input logic             viol
);
  p_no_count_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> cnt == '0);
  p_enable_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);
  p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt != '0 && !(nmi || rst_req)) |=> (cnt == $past(cnt) - CNT_W'(1)) || $past(fire));
  p_expiry_trips_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt == '0 && !(nmi || rst_req)) |=> (nmi || rst_req));
  p_one_reaction_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(nmi && rst_req));
  p_reaction_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi || rst_req) |=> $stable({nmi, rst_req}));
  p_flag_on_trip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi || rst_req) |-> viol);
  p_frozen_after_trip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi || rst_req) |=> $stable(cnt));
endmodule

bind kww_top kww_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk_i), .rst_n(rst_ni), .en(en_w), .fire(fire_w), .cnt(cnt_w),
  .nmi(nmi_o), .rst_req(rst_req_o), .viol(viol_w)
);

// File: tb/kww_top_tb_top.sv
`timescale 1ns/1ps
module kww_top_tb_top;
  localparam logic [7:0] A_CTRL = 8'h00, A_LOAD = 8'h04, A_KEY = 8'h08, A_STAT = 8'h0C,
                         A_CNT = 8'h10, A_REACT = 8'h14, A_WIN = 8'h18;
  localparam logic [31:0] UNLOCK = 32'hA985_59DA;
  localparam logic [31:0] K1 = 32'hE51A, K2 = 32'hA35C;
  localparam int L = 4 << 3; // period field 4, SHIFT 3

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic nmi, rreq;
  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;

  always #4 clk = ~clk;

  kww_top #(.ADDR_W(8), .PRE_W(12), .SHIFT(3)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .nmi_o(nmi), .rst_req_o(rreq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: read data is due one cycle after the strobe
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("scoreboard underrun", 32'h1, 32'h0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] win, input logic [31:0] react);
    do_reset();
    wr(A_LOAD, 32'd4); wr(A_WIN, win); wr(A_REACT, react);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, actual running expected done");
    summary();
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 nmi after reset", {31'b0, nmi}, 0);
    check("R1 rst_req after reset", {31'b0, rreq}, 0);
    rd(A_CTRL, 0, "R1 ctrl"); rd(A_STAT, 0, "R1 status"); rd(A_CNT, 0, "R1 counter");
    // R2 wrong unlock word
    wr(A_CTRL, 32'h1234_5678); idle(40);
    rd(A_CTRL, 0, "R2 wrong word keeps disabled"); rd(A_CNT, 0, "R2 no count while disabled");
    check("R2 no trip while disabled", {30'b0, nmi, rreq}, 0);
    // R3 field width, R11 readback and unmapped
    wr(A_LOAD, 32'hFFFF_F004); rd(A_LOAD, 32'h004, "R3 period field 12 bits");
    wr(A_WIN, 32'h50); rd(A_WIN, 32'h50, "R5 window readback");
    wr(A_REACT, 32'hA); rd(A_REACT, 32'hA, "R8 reaction readback");
    rd(8'h40, 0, "R11 unmapped reads 0");

    // in-window service, broken order, re-unlock, expiry with clear collision
    wr(A_CTRL, UNLOCK);              // edge E
    idle(5); rd(A_CNT, L - 5, "R3 counter falls one per clock");
    idle(14); wr(A_KEY, K1); wr(A_KEY, K2);   // serve at counter 11, window 16
    rd(A_CNT, L, "R6 in-window service reloads");
    rd(A_STAT, 0, "R6 no flag on valid service");
    wr(A_KEY, K1); wr(A_KEY, 32'h1234); wr(A_KEY, K2);
    rd(A_CNT, L - 5, "R4 broken order does not reload");
    wr(A_CTRL, UNLOCK); wr(A_CTRL, 0);
    rd(A_CTRL, 1, "R2 cannot be disabled");
    rd(A_CNT, L - 9, "R2 second unlock does not reload");
    idle(22);
    check("R7 no trip before counter empties", {31'b0, nmi}, 0);
    wr(A_STAT, 32'h2);               // lands on the expiry edge
    check("R8 nmi on expiry", {30'b0, nmi, rreq}, 32'h2);
    rd(A_STAT, 32'h2, "R9 set wins over clear");
    wr(A_STAT, 32'h2);
    rd(A_STAT, 0, "R9 write-1 clears flag");
    check("R9 clear keeps reaction", {31'b0, nmi}, 1);
    rd(A_CNT, 0, "R7 counter stays at zero");

    // early service, reset reaction, freeze
    setup(32'h50, 32'h0);
    wr(A_CTRL, UNLOCK); idle(2); wr(A_KEY, K1); wr(A_KEY, K2);  // counter 29
    check("R6 early service trips to reset", {30'b0, nmi, rreq}, 32'h1);
    rd(A_STAT, 32'h2, "R9 flag on early service");
    rd(A_CNT, 29, "R10 counter frozen at trip");
    wr(A_KEY, K1); wr(A_KEY, K2); idle(5);
    rd(A_CNT, 29, "R10 service ignored after trip");
    wr(A_REACT, 32'hA); idle(1);
    check("R8 reaction fixed at trip", {30'b0, nmi, rreq}, 32'h1);

    // quarter window: 9 is early, 8 is open
    setup(32'h500, 32'hA);
    wr(A_CTRL, UNLOCK); idle(22); wr(A_KEY, K1); wr(A_KEY, K2);
    check("R5 quarter window early at 9", {31'b0, nmi}, 1);
    setup(32'h500, 32'hA);
    wr(A_CTRL, UNLOCK); idle(23); wr(A_KEY, K1); wr(A_KEY, K2);
    rd(A_CNT, L, "R5 quarter window open at 8");
    check("R5 no trip at 8", {31'b0, nmi}, 0);
    // eighth window: 5 is early, 4 is open
    setup(32'h5000, 32'hA);
    wr(A_CTRL, UNLOCK); idle(26); wr(A_KEY, K1); wr(A_KEY, K2);
    check("R5 eighth window early at 5", {31'b0, nmi}, 1);
    setup(32'h5000, 32'hA);
    wr(A_CTRL, UNLOCK); idle(27); wr(A_KEY, K1); wr(A_KEY, K2);
    rd(A_CNT, L, "R5 eighth window open at 4");
    // unknown code means whole period
    setup(32'h77, 32'hA);
    wr(A_CTRL, UNLOCK); idle(1); wr(A_KEY, K1); wr(A_KEY, K2);
    rd(A_CNT, L, "R5 unknown code gives full window");
    check("R5 no trip with full window", {31'b0, nmi}, 0);
    // last tick: counter 1 serves, counter 0 trips
    setup(32'h5, 32'hA);
    wr(A_CTRL, UNLOCK); idle(30); wr(A_KEY, K1); wr(A_KEY, K2);
    rd(A_CNT, L, "R7 service at counter 1 reloads");
    check("R7 no trip at counter 1", {31'b0, nmi}, 0);
    setup(32'h5, 32'hA);
    wr(A_CTRL, UNLOCK); idle(31); wr(A_KEY, K1); wr(A_KEY, K2);
    check("R7 service at counter 0 still trips", {31'b0, nmi}, 1);
    rd(A_CNT, 0, "R7 counter zero after late service");

    idle(2);
    summary();
  end
endmodule